// File: doc/BRIEF.md
# Reset Source Sequencer

This block gathers every reason the chip can have for resetting itself and turns them into one internal system reset. Once a reset is accepted it pulls the shared open-drain reset pad low for a fixed stretch of bus cycles. It then lets go of the pad, waits a second fixed stretch and samples the pad. A pad still held low at that sample means something outside the chip is asserting reset, and the pad is then recorded as the cause. While the sequence runs, a select output keeps the clock generator in its free-running self-clocked mode.

The sources are a power-on input, an illegal-opcode flag, a debug-forced request, clock loss-of-lock, clock loss-of-clock, a watchdog timeout and the pad itself. The pad can be masked with an enable input. A read-only cause register keeps a one-hot record of why the last reset happened. The debug request has no bit of its own. When several requests arrive in the same cycle, a fixed priority picks the single cause that is recorded. The pad input must already be synchronous to `clk`, because the pad synchronizer belongs to the I/O ring.

Top module: `rst_seq_ctrl`

## Requirements
- R1: While `por_n` is low, `sys_rst`, `pin_drive_low` and `self_clk_sel` are 1 and `rst_cause` equals 6'b000001, which is the power-on bit (bit 0).
- R2: After `por_n` rises, `pin_drive_low` falls on the 34th rising clock edge and `sys_rst` falls on the 72nd. `rst_cause` keeps the power-on bit.
- R3: A request seen in an idle cycle is accepted at the next rising edge. From that edge `sys_rst`, `self_clk_sel` and `pin_drive_low` are 1, and `pin_drive_low` stays 1 for exactly 34 cycles.
- R4: `sys_rst` and `self_clk_sel` stay 1 for exactly 72 cycles from the accepting edge: 34 drive cycles plus 38 release cycles. Both are 0 afterwards.
- R5: On acceptance, `rst_cause` is cleared and then holds at most one bit, the highest-priority internal source present. The order, highest first, is clock loss (bit 5), loss of lock (bit 4), illegal opcode (bit 3) and watchdog (bit 2).
- R6: A debug-forced request starts a full sequence but sets no cause bit of its own.
- R7: Bit 1 (pad) is set at the edge that ends the release window only if `pin_in` is low in the cycle before that edge, `pin_rst_en` is 1 and no other cause was recorded at acceptance. A pad pulse that is gone by then leaves `rst_cause` at zero.
- R8: With `pin_rst_en` at 0, a low `pin_in` neither starts a reset nor sets the pad bit.
- R9: Requests that arrive while a sequence is running are ignored. They neither lengthen the sequence nor change `rst_cause`.
- R10: Between sequences `rst_cause` holds its value and `sys_rst` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| por_n | input | 1 | Asynchronous active-low power-on reset |
| illegal_op | input | 1 | Illegal-opcode reset request |
| dbg_rst_req | input | 1 | Debug-forced reset request (no cause bit) |
| lock_lost | input | 1 | Clock generator lost lock |
| clk_lost | input | 1 | Clock generator lost its reference clock |
| wdog_tmo | input | 1 | Watchdog timeout |
| pin_in | input | 1 | Synchronised level of the reset pad |
| pin_rst_en | input | 1 | 1 lets a low pad act as a reset source |
| sys_rst | output | 1 | Internal system reset, active high |
| pin_drive_low | output | 1 | Enables the open-drain pull-down on the pad |
| self_clk_sel | output | 1 | Forces the clock generator into self-clocked mode |
| rst_cause | output | 6 | One-hot cause record: 5 clock loss, 4 lock loss, 3 illegal opcode, 2 watchdog, 1 pad, 0 power-on |

## Verification
A request driven before edge N shows up on `sys_rst`, `self_clk_sel`, `pin_drive_low` and the entry value of `rst_cause` right after edge N. The drive output is then counted over 34 cycles and the reset over 72. The pad bit appears only after the edge that closes the window, 72 edges after acceptance, so the final cause is read once `sys_rst` has been seen low. The bench drives inputs on falling edges and counts its observations on falling edges, so every count of high cycles maps directly onto the edge arithmetic in R2 to R4. It sweeps every combination of the four internal sources, with and without a debug request and with a pad held low.

// File: rtl/rsq_pkg.sv
package rsq_pkg;

    localparam int NCAUSE    = 6;
    localparam int NINT      = 4;
    localparam int C_POR     = 0;
    localparam int C_PIN     = 1;
    localparam int C_WDOG    = 2;
    localparam int C_ILLOP   = 3;
    localparam int C_LOCK    = 4;
    localparam int C_CLKLOSS = 5;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_DRIVE = 2'd1,
        PH_WAIT  = 2'd2
    } phase_e;

endpackage

// File: rtl/rsq_arbiter.sv
module rsq_arbiter #(
    parameter int NREQ = 4
) (
    input  logic [NREQ-1:0] req,
    output logic [NREQ-1:0] grant,
    output logic            any
);

    // above[i] is set when some request at index i or higher is present.
    logic [NREQ:0] above;

    assign above[NREQ] = 1'b0;

    for (genvar i = 0; i < NREQ; i++) begin : g_prio
        assign grant[i] = req[i] & ~above[i+1];
        assign above[i] = above[i+1] | req[i];
    end

    assign any = above[0];

    // R5: never more than one winner, and a winner whenever something asks
    always_comb begin
        a_r5_grant_onehot: assert ($onehot0(grant));
        a_r5_grant_present: assert (req == '0 || grant != '0);
    end

endmodule

// File: rtl/rsq_phase_timer.sv
module rsq_phase_timer
    import rsq_pkg::*;
#(
    parameter int DRIVE_CYC  = 34,
    parameter int SAMPLE_DLY = 38
) (
    input  logic clk,
    input  logic por_n,
    input  logic start,
    output logic busy,
    output logic drive,
    output logic sample_now
);

    localparam int MAXC  = (DRIVE_CYC > SAMPLE_DLY) ? DRIVE_CYC : SAMPLE_DLY;
    localparam int CNT_W = (MAXC > 1) ? $clog2(MAXC) : 1;
    localparam logic [CNT_W-1:0] DRIVE_LAST = CNT_W'(DRIVE_CYC - 1);
    localparam logic [CNT_W-1:0] WAIT_LAST  = CNT_W'(SAMPLE_DLY - 1);

    typedef struct packed {
        phase_e           ph;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        sample_now = 1'b0;
        case (st_q.ph)
            PH_IDLE: begin
                if (start) begin
                    st_d.ph  = PH_DRIVE;
                    st_d.cnt = '0;
                end
            end
            PH_DRIVE: begin
                if (st_q.cnt == DRIVE_LAST) begin
                    st_d.ph  = PH_WAIT;
                    st_d.cnt = '0;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
            PH_WAIT: begin
                if (st_q.cnt == WAIT_LAST) begin
                    st_d.ph    = PH_IDLE;
                    st_d.cnt   = '0;
                    sample_now = 1'b1;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
            default: begin
                st_d.ph  = PH_IDLE;
                st_d.cnt = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            st_q <= '{ph: PH_DRIVE, cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign busy  = (st_q.ph != PH_IDLE);
    assign drive = (st_q.ph == PH_DRIVE);

    // R3: a start seen while idle lands in the drive phase one edge later
    a_r3_start_enters_drive: assert property (@(posedge clk) disable iff (!por_n)
        (!busy && start) |=> drive);

    // R4: the drive phase always hands over to the release window
    a_r4_release_follows_drive: assert property (@(posedge clk) disable iff (!por_n)
        $fell(drive) |-> busy);

    // R4: the window ends only through the sampling step
    a_r4_end_via_sample: assert property (@(posedge clk) disable iff (!por_n)
        $fell(busy) |-> $past(sample_now));

endmodule

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl
    import rsq_pkg::*;
#(
    parameter int DRIVE_CYC  = 34,
    parameter int SAMPLE_DLY = 38
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              illegal_op,
    input  logic              dbg_rst_req,
    input  logic              lock_lost,
    input  logic              clk_lost,
    input  logic              wdog_tmo,
    input  logic              pin_in,
    input  logic              pin_rst_en,
    output logic              sys_rst,
    output logic              pin_drive_low,
    output logic              self_clk_sel,
    output logic [NCAUSE-1:0] rst_cause
);

    typedef struct packed {
        logic [NCAUSE-1:0] cause;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [NINT-1:0] int_req;
    logic [NINT-1:0] int_win;
    logic            int_any;
    logic            pin_req;
    logic            start;
    logic            busy;
    logic            drive;
    logic            sample_now;

    // order follows the cause bits 2..5 so the winner drops straight in
    assign int_req = {clk_lost, lock_lost, illegal_op, wdog_tmo};
    assign pin_req = pin_rst_en & ~pin_in;
    assign start   = int_any | dbg_rst_req | pin_req;

    rsq_arbiter #(
        .NREQ (NINT)
    ) u_arb (
        .req   (int_req),
        .grant (int_win),
        .any   (int_any)
    );

    rsq_phase_timer #(
        .DRIVE_CYC  (DRIVE_CYC),
        .SAMPLE_DLY (SAMPLE_DLY)
    ) u_tmr (
        .clk        (clk),
        .por_n      (por_n),
        .start      (start),
        .busy       (busy),
        .drive      (drive),
        .sample_now (sample_now)
    );

    always_comb begin
        ctl_d = ctl_q;
        if (!busy && start) begin
            ctl_d.cause = {int_win, 2'b00};
        end else if (sample_now && ctl_q.cause == '0 && pin_rst_en && !pin_in) begin
            ctl_d.cause[C_PIN] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            ctl_q.cause <= NCAUSE'(1) << C_POR;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign sys_rst       = busy;
    assign self_clk_sel  = busy;
    assign pin_drive_low = drive;
    assign rst_cause     = ctl_q.cause;

    // R5: the record is one-hot or empty at all times
    a_r5_cause_onehot: assert property (@(posedge clk) disable iff (!por_n)
        $onehot0(rst_cause));

    // R9: nothing rewrites the record once the pad is being driven
    a_r9_frozen_in_drive: assert property (@(posedge clk) disable iff (!por_n)
        (pin_drive_low && $past(pin_drive_low)) |-> $stable(rst_cause));

    // R10: the record holds between sequences
    a_r10_hold_idle: assert property (@(posedge clk) disable iff (!por_n)
        (!sys_rst && !$past(sys_rst)) |-> $stable(rst_cause));

    // R7: the pad bit appears only at the end of the window with the pad low and enabled
    a_r7_pad_bit_origin: assert property (@(posedge clk) disable iff (!por_n)
        $rose(rst_cause[C_PIN]) |-> ($fell(sys_rst) && !$past(pin_in) && $past(pin_rst_en)));

    // R3: the pad is only pulled while the system is held in reset
    a_r3_drive_inside_reset: assert property (@(posedge clk) disable iff (!por_n)
        pin_drive_low |-> (sys_rst && self_clk_sel));

endmodule

// File: tb/rst_seq_ctrl_bench.sv
module rst_seq_ctrl_bench;

    logic       clk = 1'b0;
    logic       por_n;
    logic       illegal_op, dbg_rst_req, lock_lost, clk_lost, wdog_tmo;
    logic       pin_in, pin_rst_en;
    logic       sys_rst, pin_drive_low, self_clk_sel;
    logic [5:0] rst_cause;

    int n_vec = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    rst_seq_ctrl u_rst_seq_ctrl (
        .clk           (clk),
        .por_n         (por_n),
        .illegal_op    (illegal_op),
        .dbg_rst_req   (dbg_rst_req),
        .lock_lost     (lock_lost),
        .clk_lost      (clk_lost),
        .wdog_tmo      (wdog_tmo),
        .pin_in        (pin_in),
        .pin_rst_en    (pin_rst_en),
        .sys_rst       (sys_rst),
        .pin_drive_low (pin_drive_low),
        .self_clk_sel  (self_clk_sel),
        .rst_cause     (rst_cause)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // highest set bit of the 4-bit internal pattern wins; bit k maps to cause bit k+2
    function automatic int entry_cause(input logic [3:0] pat);
        int r = 0;
        for (int i = 0; i < 4; i++) begin
            if (pat[i]) r = 1 << (i + 2);
        end
        return r;
    endfunction

    task automatic run_case(input logic [3:0] pat, input logic dbg,
                            input logic pin_low, input logic en, input logic mid,
                            input string tag);
        int dc;
        int rc;
        int ent;
        int fin;
        ent = entry_cause(pat);
        fin = (ent != 0) ? ent : ((pin_low && en) ? 2 : 0);
        @(negedge clk);
        {clk_lost, lock_lost, illegal_op, wdog_tmo} = pat;
        dbg_rst_req = dbg;
        pin_rst_en  = en;
        pin_in      = !pin_low;
        @(negedge clk);
        {clk_lost, lock_lost, illegal_op, wdog_tmo} = 4'b0000;
        dbg_rst_req = 1'b0;
        chk({"R3 entry sys_rst ", tag}, sys_rst, 1);
        chk({"R3 entry drive ", tag}, pin_drive_low, 1);
        chk({"R3 entry self_clk_sel ", tag}, self_clk_sel, 1);
        chk({"R5 entry cause ", tag}, rst_cause, ent);
        dc = 1;
        rc = 1;
        for (int k = 0; k < 300 && sys_rst; k++) begin
            wdog_tmo = (mid && rc == 10);
            @(negedge clk);
            if (sys_rst) rc++;
            if (pin_drive_low) dc++;
        end
        wdog_tmo   = 1'b0;
        pin_in     = 1'b1;
        pin_rst_en = 1'b1;
        chk({"R3 drive cycles ", tag}, dc, 34);
        chk({"R4 reset cycles ", tag}, rc, 72);
        chk({"R4 self_clk_sel released ", tag}, self_clk_sel, 0);
        chk({tag, " final cause"}, rst_cause, fin);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk({"R10 idle sys_rst ", tag}, sys_rst, 0);
            chk({"R10 idle cause ", tag}, rst_cause, fin);
        end
    endtask

    initial begin
        #1_500_000ns;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        int dc;
        int rc;
        int hold;
        por_n = 1'b0;
        {clk_lost, lock_lost, illegal_op, wdog_tmo, dbg_rst_req} = 5'b00000;
        pin_in     = 1'b1;
        pin_rst_en = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 por sys_rst", sys_rst, 1);
        chk("R1 por drive", pin_drive_low, 1);
        chk("R1 por self_clk_sel", self_clk_sel, 1);
        chk("R1 por cause", rst_cause, 1);

        por_n = 1'b1;
        dc = 0;
        rc = 0;
        for (int k = 0; k < 200; k++) begin
            @(negedge clk);
            if (pin_drive_low) dc++;
            if (sys_rst) rc++;
        end
        chk("R2 drive after por", dc, 33);
        chk("R2 reset after por", rc, 71);
        chk("R2 cause after por", rst_cause, 1);

        // R5 / R6: every internal pattern, with and without a debug request
        for (int d = 0; d < 2; d++) begin
            for (int p = 0; p < 16; p++) begin
                if (p == 0 && d == 0) continue;
                run_case(4'(p), 1'(d), 1'b0, 1'b1, 1'b0, (p == 0) ? "R6" : "R5");
            end
        end

        // R7: pad held low through the sample, alone or with internal causes
        for (int p = 0; p < 16; p++) begin
            run_case(4'(p), 1'b0, 1'b1, 1'b1, 1'b0, "R7");
        end

        // R8: pad held low but masked, internal cause present
        for (int p = 1; p < 16; p++) begin
            run_case(4'(p), 1'b0, 1'b1, 1'b0, 1'b0, "R8");
        end

        // R9: a watchdog pulse mid-sequence is ignored
        run_case(4'b0100, 1'b0, 1'b0, 1'b1, 1'b1, "R9");
        run_case(4'b0000, 1'b1, 1'b0, 1'b1, 1'b1, "R9");

        // R7: one-cycle pad pulse starts a reset but is gone at the sample
        @(negedge clk);
        pin_in = 1'b0;
        @(negedge clk);
        pin_in = 1'b1;
        chk("R7 pulse starts reset", sys_rst, 1);
        for (int k = 0; k < 300 && sys_rst; k++) @(negedge clk);
        chk("R7 pulse leaves no cause", rst_cause, 0);

        // R8: masked pad low with nothing else pending does nothing
        run_case(4'b1000, 1'b0, 1'b0, 1'b1, 1'b0, "R5");
        @(negedge clk);
        pin_rst_en = 1'b0;
        pin_in     = 1'b0;
        hold       = 0;
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            if (sys_rst) hold++;
        end
        chk("R8 masked pad no reset", hold, 0);
        chk("R8 masked pad cause kept", rst_cause, 32);
        pin_in     = 1'b1;
        pin_rst_en = 1'b1;
        repeat (2) @(negedge clk);

        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule